// File: doc/BRIEF.md
# Sub-Processor Interrupt Controller

This block gathers five interrupt event sources for a sub-processor and turns them into a single encoded interrupt level. The sources are graphics-operation completion, a request from the main processor, a timer, a drive status event and a data decoder event. Each source has a pending latch. A software-written enable mask chooses which pending sources may reach the processor. The output is the number of the highest enabled pending level, or 0 when no level is active. The processor clears a level by presenting an acknowledge that carries that level number.

Sources are not all treated the same way when an event arrives while the source is disabled:
- Graphics completion events are thrown away.
- Drive and decoder events are remembered until the mask lets them through.
- Main-processor and timer events are thrown away. Writing a mask that disables one of these two levels also wipes any request already pending on it.

Events arrive as single-cycle pulses. The mask port is a plain write strobe with data. There is no back-pressure anywhere, because every input is sampled on every clock.

Top module: `sub_irq_ctrl`

## Requirements
- R1: `irq_level` reports the number (1 to 5) of the highest level that is both pending and enabled, or 0 when there is none. Bit i of `evt_pulse`, `mask_wdata` and the mask refers to level i+1: 1 = graphics done, 2 = main-processor request, 3 = timer, 4 = drive, 5 = decoder.
- R2: A level 1 event that arrives while level 1 is disabled is not latched. Enabling level 1 afterwards gives no interrupt.
- R3: Level 4 and level 5 events are latched even while disabled. They appear on `irq_level` once their mask bit is set.
- R4: A level 2 event that arrives while level 2 is disabled is discarded. A mask write with bit 1 = 0 clears the level 2 pending bit. This clear wins over a level 2 event in the same cycle.
- R5: Level 3 follows the same rules as level 2: it discards events while disabled and is cleared by a mask write that disables it.
- R6: When several enabled levels are pending, the higher number wins. Level 5 is served before level 4.
- R7: An acknowledge with `ack_level` = n clears only level n's pending bit. An event on level n in the same cycle as its acknowledge stays pending.
- R8: A mask write takes effect on the next clock. An event in the same cycle as the mask write is judged against the mask as it was before the write.
- R9: Reset clears every pending bit and the mask, so `irq_level` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 5 | One-cycle event pulses, bit i = level i+1 |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 5 | New mask value, bit i enables level i+1 |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level number being acknowledged |
| irq_level | output | 3 | Highest enabled pending level, 0 for none |

## Verification
Any wrong internal state has only one place to show up: `irq_level`. It becomes visible in the first cycle after the corrupting edge in which the affected level is both enabled and the highest pending level. The hardest cases are the ones where the error stays hidden behind the mask. Examples are a graphics event latched while it should have been dropped, or a level 2 request that survives a disabling write. These are exposed by re-enabling the level with nothing higher pending and checking that the output stays 0. Priority faults are exposed by raising levels 4 and 5 together and acknowledging them one at a time.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NUM_LVL = 5;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);

  // What happens to an event seen while its level is disabled
  typedef enum logic [1:0] {
    POL_DROP       = 2'd0,  // discard event, keep existing pending state
    POL_CLR_ON_DIS = 2'd1,  // discard event, disabling write wipes pending
    POL_HOLD       = 2'd2   // always latch, wait for enable
  } pol_e;

  function automatic pol_e level_policy(int lvl);
    case (lvl)
      1:       return POL_DROP;
      2, 3:    return POL_CLR_ON_DIS;
      default: return POL_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/sirq_src_latch.sv
module sirq_src_latch #(
  parameter sirq_pkg::pol_e POLICY = sirq_pkg::POL_HOLD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en,
  input  logic dis_wr,
  input  logic ack_hit,
  output logic pend
);
  logic take_evt;
  logic wipe;

  generate
    if (POLICY == sirq_pkg::POL_HOLD) begin : g_hold
      assign take_evt = evt;
      assign wipe     = 1'b0;
    end else if (POLICY == sirq_pkg::POL_CLR_ON_DIS) begin : g_clr
      assign take_evt = evt & en;
      assign wipe     = dis_wr;
    end else begin : g_drop
      assign take_evt = evt & en;
      assign wipe     = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (wipe)     pend <= 1'b0;
    else if (take_evt) pend <= 1'b1;
    else if (ack_hit)  pend <= 1'b0;
  end
endmodule

// File: rtl/sirq_prio_enc.sv
module sirq_prio_enc #(
  parameter int N = 5,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] active,
  output logic [W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < N; i++) begin
      if (active[i]) level = W'(i + 1);
    end
  end
endmodule

// File: rtl/sub_irq_ctrl.sv
module sub_irq_ctrl (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [sirq_pkg::NUM_LVL-1:0] evt_pulse,
  input  logic                        mask_we,
  input  logic [sirq_pkg::NUM_LVL-1:0] mask_wdata,
  input  logic                        ack_valid,
  input  logic [sirq_pkg::LVL_W-1:0]   ack_level,
  output logic [sirq_pkg::LVL_W-1:0]   irq_level
);
  localparam int N = sirq_pkg::NUM_LVL;
  localparam int W = sirq_pkg::LVL_W;

  logic [N-1:0] mask_q;
  logic [N-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_src
      sirq_src_latch #(.POLICY(sirq_pkg::level_policy(g + 1))) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_pulse[g]),
        .en      (mask_q[g]),
        .dis_wr  (mask_we & ~mask_wdata[g]),
        .ack_hit (ack_valid && (ack_level == W'(g + 1))),
        .pend    (pend[g])
      );
    end
  endgenerate

  sirq_prio_enc #(.N(N), .W(W)) u_enc (
    .active (pend & mask_q),
    .level  (irq_level)
  );
endmodule

// File: rtl/sub_irq_ctrl_chk.sv
module sub_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] evt_pulse,
  input logic       mask_we,
  input logic [4:0] mask_wdata,
  input logic       ack_valid,
  input logic [2:0] ack_level,
  input logic [2:0] irq_level,
  input logic [4:0] mask_q,
  input logic [4:0] pend
);
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level <= 3'd5);  // R1

  AST_GFX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[0] && evt_pulse[0] && !pend[0]) |=> !pend[0]);  // R2

  AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[3] |=> pend[3]);  // R3

  AST_HOST_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !mask_wdata[1]) |=> !pend[1]);  // R4

  AST_TIMER_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !mask_wdata[2]) |=> !pend[2]);  // R5

  AST_DEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[4] && mask_q[4]) |-> irq_level == 3'd5);  // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level == 3'd5 && !evt_pulse[4]) |=> !pend[4]);  // R7

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_wdata == 5'd0) |=> irq_level == 3'd0);  // R8
endmodule

bind sub_irq_ctrl sub_irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_pulse  (evt_pulse),
  .mask_we    (mask_we),
  .mask_wdata (mask_wdata),
  .ack_valid  (ack_valid),
  .ack_level  (ack_level),
  .irq_level  (irq_level),
  .mask_q     (mask_q),
  .pend       (pend)
);

// File: tb/sub_irq_ctrl_bench.sv
module sub_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_pulse = '0;
  logic       mask_we = 1'b0;
  logic [4:0] mask_wdata = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_level = '0;
  logic [2:0] irq_level;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sub_irq_ctrl u_sub_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: irq_level=%0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, push the level expected after the edge
  task automatic cyc(input logic [4:0] ev, input logic we, input logic [4:0] wd,
                     input logic av, input logic [2:0] al, input int exp,
                     input string tag);
    @(negedge clk);
    evt_pulse = ev; mask_we = we; mask_wdata = wd; ack_valid = av; ack_level = al;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    evt_pulse = '0; mask_we = 1'b0; ack_valid = 1'b0;
  endtask

  // Monitor: compare one item after each edge that follows a driven cycle
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(int'(irq_level), e, t);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(irq_level), 0, "R9 reset state");
    rst_n = 1'b1;
    cyc(5'b00001, 0, 5'b00000, 0, 0, 0, "R2 gfx masked");
    cyc(5'b00000, 1, 5'b00001, 0, 0, 0, "R2 unmask no irq");
    cyc(5'b00001, 0, 5'b00000, 0, 0, 1, "R1 gfx enabled");
    cyc(5'b00000, 0, 5'b00000, 1, 1, 0, "R7 ack gfx");
    cyc(5'b01000, 0, 5'b00000, 0, 0, 0, "R3 drive held masked");
    cyc(5'b10000, 0, 5'b00000, 0, 0, 0, "R3 decoder held masked");
    cyc(5'b00000, 1, 5'b11001, 0, 0, 5, "R6 decoder over drive");
    cyc(5'b00000, 0, 5'b00000, 1, 5, 4, "R7 ack 5 leaves 4");
    cyc(5'b01000, 0, 5'b00000, 1, 4, 4, "R7 event beats ack");
    cyc(5'b00000, 0, 5'b00000, 1, 4, 0, "R7 ack 4");
    cyc(5'b00010, 0, 5'b00000, 0, 0, 0, "R4 host masked");
    cyc(5'b00000, 1, 5'b11011, 0, 0, 0, "R4 enable no irq");
    cyc(5'b00010, 0, 5'b00000, 0, 0, 2, "R1 host enabled");
    cyc(5'b00000, 1, 5'b11001, 0, 0, 0, "R4 disable");
    cyc(5'b00000, 1, 5'b11011, 0, 0, 0, "R4 wiped on disable");
    cyc(5'b00010, 1, 5'b11001, 0, 0, 0, "R4 wipe vs event");
    cyc(5'b00000, 1, 5'b11011, 0, 0, 0, "R4 wipe won");
    cyc(5'b00000, 1, 5'b11001, 0, 0, 0, "R5 timer off");
    cyc(5'b00100, 0, 5'b00000, 0, 0, 0, "R5 timer masked");
    cyc(5'b00000, 1, 5'b11111, 0, 0, 0, "R5 enable no irq");
    cyc(5'b00100, 0, 5'b00000, 0, 0, 3, "R5 timer enabled");
    cyc(5'b00001, 0, 5'b00000, 0, 0, 3, "R6 timer over gfx");
    cyc(5'b00000, 0, 5'b00000, 1, 3, 1, "R7 ack 3 leaves 1");
    cyc(5'b00000, 0, 5'b00000, 1, 1, 0, "R7 ack 1");
    cyc(5'b00001, 1, 5'b00000, 0, 0, 0, "R8 event judged by old mask");
    cyc(5'b00000, 1, 5'b00001, 0, 0, 1, "R8 latched under old mask");
    cyc(5'b00000, 0, 5'b00000, 1, 1, 0, "R8 ack");
    cyc(5'b10000, 1, 5'b00000, 0, 0, 0, "R3 decoder pending");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(int'(irq_level), 0, "R9 reset mid-run");
    rst_n = 1'b1;
    cyc(5'b00000, 1, 5'b10000, 0, 0, 0, "R9 pending cleared");
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cnt;
    cnt = 0;
    while (!done && cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: ran %0d cycles, expected completion", cnt);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule